// File: doc/BRIEF.md
# Page Write Buffer and Self-Timed Commit Engine

This block sits behind the command layer of a serial byte-wide memory with 256 locations arranged as 16 rows of 16 bytes. During a write transaction it takes the byte address once, then gathers each following data byte into a 16-entry row buffer. A 16-bit mask records which columns have been filled. It returns a per-byte acknowledge decision that the command layer drives onto the bus.

When the command layer reports a stop placed in the slot directly after an acknowledge, the engine copies the filled entries into the array over a write port, one column per cycle and in ascending column order. It then waits for a programmable hold time. The busy flag stays high for the whole cycle, so the command layer can refuse device selects and a master can poll for completion. A stop in any other slot throws away the collected bytes.

A write-protect sample is watched from the start condition up to and including the address-load cycle. If it is seen high at any point in that window, the whole transaction is treated as protected.

Top module: `pgwr_engine`

## Requirements
- R1: After reset, `busy`, `ack_valid` and `mem_we` are all 0.
- R2: An accepted data byte produces `ack_valid`=1 with `ack_ok`=1 in the cycle after its `data_stb` cycle. A byte is accepted when the engine is idle, the transaction is unprotected and an address has been loaded.
- R3: The buffered byte lands at column `addr[3:0]` of row `addr[7:4]`, where addr is the loaded address. After each accepted byte only the column advances, modulo 16. The row never changes, so a page that runs past column 15 continues at column 0 of the same row.
- R4: If more than 16 bytes arrive, a later byte replaces the entry at its wrapped column. Each location is still written at most once per commit, and it takes the last value received for it.
- R5: Only columns that received a byte are written. Each write lasts one cycle. Writes go in ascending column order, and every other byte of the row keeps its previous content.
- R6: A commit starts only when `stop_evt`=1 with `stop_after_ack`=1. A stop with `stop_after_ack`=0 discards the buffer: no write occurs and `busy` stays 0.
- R7: If `wp_in`=1 in any cycle from the `xfer_start` cycle through the `addr_load` cycle, every data byte of that transaction gets `ack_ok`=0, nothing is written and `busy` stays 0. A high `wp_in` after the address-load cycle has no effect.
- R8: After a committing stop, `busy` is high for exactly 16 + `WR_CYCLES` consecutive cycles.
- R9: While `busy`=1, data bytes get `ack_ok`=0 and are not stored. Start, address and stop events are ignored, so no second cycle follows.
- R10: A committing stop with no buffered byte starts no cycle, and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Start or repeated-start condition seen (one-cycle pulse) |
| wp_in | input | 1 | Write-protect pin sample |
| addr_load | input | 1 | Byte address complete (one-cycle pulse) |
| addr_in | input | 8 | Byte address |
| data_stb | input | 1 | Data byte complete (one-cycle pulse) |
| data_in | input | 8 | Data byte |
| stop_evt | input | 1 | Stop condition seen (one-cycle pulse) |
| stop_after_ack | input | 1 | Stop fell in the slot right after an acknowledge |
| ack_valid | output | 1 | Acknowledge decision valid for the last data byte |
| ack_ok | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 8 | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Self-timed write cycle in progress |

## Verification
The bench builds the engine with the default 8-bit address, 4-bit column and 8-bit data widths. It shortens `WR_CYCLES` to 24, which puts the exact busy length, polling during a cycle and several back-to-back transactions within a short run. The full row width remains, so column wrap and overflow past 16 bytes are both reachable.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DRAIN = 2'd1,
        PH_HOLD  = 2'd2
    } phase_e;

    // total busy span of one committed cycle: one drain slot per column plus hold
    function automatic int unsigned busy_span(int unsigned page, int unsigned hold);
        return page + hold;
    endfunction

endpackage

// File: rtl/pgwr_wp_guard.sv
module pgwr_wp_guard (
    input  logic clk,
    input  logic rst,
    input  logic live,
    input  logic xfer_start,
    input  logic addr_load,
    input  logic wp_in,
    output logic prot
);
    logic window;

    always_ff @(posedge clk) begin
        if (rst) begin
            window <= 1'b0;
            prot   <= 1'b0;
        end else if (live) begin
            if (xfer_start) begin
                window <= 1'b1;
                prot   <= wp_in;
            end else if (window) begin
                prot <= prot | wp_in;
                if (addr_load)
                    window <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pgwr_page_buf.sv
module pgwr_page_buf #(
    parameter int ADDR_W = 8,
    parameter int COL_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    live,
    input  logic                    open_txn,
    input  logic                    end_txn,
    input  logic                    flush,
    input  logic                    addr_load,
    input  logic [ADDR_W-1:0]       addr_in,
    input  logic                    data_stb,
    input  logic [DATA_W-1:0]       data_in,
    input  logic                    accept,
    input  logic [COL_W-1:0]        rd_idx,
    output logic [ADDR_W-COL_W-1:0] row,
    output logic [(1<<COL_W)-1:0]   fill_mask,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    ack_valid,
    output logic                    ack_ok
);
    localparam int ROW_W = ADDR_W - COL_W;
    localparam int PAGE  = 1 << COL_W;

    logic [COL_W-1:0]  col;
    logic              have_addr;
    logic [DATA_W-1:0] entry [PAGE];
    logic              take;

    assign take    = data_stb && accept && have_addr;
    assign rd_data = entry[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            row       <= '0;
            col       <= '0;
            have_addr <= 1'b0;
            fill_mask <= '0;
            ack_valid <= 1'b0;
            ack_ok    <= 1'b0;
        end else begin
            ack_valid <= data_stb;
            ack_ok    <= take;
            if (flush)
                fill_mask <= '0;
            if (live && (open_txn || end_txn))
                have_addr <= 1'b0;
            if (live && addr_load) begin
                row       <= addr_in[ADDR_W-1:COL_W];
                col       <= addr_in[COL_W-1:0];
                have_addr <= 1'b1;
            end
            if (take) begin
                fill_mask[col] <= 1'b1;
                col            <= col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (take)
            entry[col] <= data_in;
    end

    logic [ROW_W-1:0] unused_row_w;
    assign unused_row_w = '0;
endmodule

// File: rtl/pgwr_commit_seq.sv
module pgwr_commit_seq
    import pgwr_pkg::*;
#(
    parameter int COL_W     = 4,
    parameter int WR_CYCLES = 1000000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    output phase_e           phase,
    output logic [COL_W-1:0] idx,
    output logic             done
);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(WR_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign done = (phase == PH_HOLD) && (cnt == HOLD_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            idx   <= '0;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    idx <= '0;
                    if (go)
                        phase <= PH_DRAIN;
                end
                PH_DRAIN: begin
                    idx <= idx + 1'b1;
                    if (&idx) begin
                        phase <= PH_HOLD;
                        cnt   <= '0;
                    end
                end
                PH_HOLD: begin
                    if (cnt == HOLD_LAST)
                        phase <= PH_IDLE;
                    else
                        cnt <= cnt + 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pgwr_engine.sv
module pgwr_engine
    import pgwr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int COL_W     = 4,
    parameter int DATA_W    = 8,
    parameter int WR_CYCLES = 1000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_start,
    input  logic              wp_in,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              data_stb,
    input  logic [DATA_W-1:0] data_in,
    input  logic              stop_evt,
    input  logic              stop_after_ack,
    output logic              ack_valid,
    output logic              ack_ok,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy
);
    localparam int ROW_W = ADDR_W - COL_W;
    localparam int PAGE  = 1 << COL_W;

    phase_e            phase;
    logic [COL_W-1:0]  idx;
    logic              done;
    logic              prot;
    logic              live;
    logic              go;
    logic              discard;
    logic              flush;
    logic [ROW_W-1:0]  row;
    logic [PAGE-1:0]   fill_mask;

    assign busy    = (phase != PH_IDLE);
    assign live    = !busy;
    assign go      = live && stop_evt && stop_after_ack && !prot && (|fill_mask);
    assign discard = live && (xfer_start || (stop_evt && !go));
    assign flush   = discard || done;

    pgwr_wp_guard u_guard (
        .clk        (clk),
        .rst        (rst),
        .live       (live),
        .xfer_start (xfer_start),
        .addr_load  (addr_load),
        .wp_in      (wp_in),
        .prot       (prot)
    );

    pgwr_page_buf #(
        .ADDR_W (ADDR_W),
        .COL_W  (COL_W),
        .DATA_W (DATA_W)
    ) u_buf (
        .clk       (clk),
        .rst       (rst),
        .live      (live),
        .open_txn  (xfer_start),
        .end_txn   (stop_evt),
        .flush     (flush),
        .addr_load (addr_load),
        .addr_in   (addr_in),
        .data_stb  (data_stb),
        .data_in   (data_in),
        .accept    (live && !prot),
        .rd_idx    (idx),
        .row       (row),
        .fill_mask (fill_mask),
        .rd_data   (mem_wdata),
        .ack_valid (ack_valid),
        .ack_ok    (ack_ok)
    );

    pgwr_commit_seq #(
        .COL_W     (COL_W),
        .WR_CYCLES (WR_CYCLES)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .go    (go),
        .phase (phase),
        .idx   (idx),
        .done  (done)
    );

    assign mem_we   = (phase == PH_DRAIN) && fill_mask[idx];
    assign mem_addr = {row, idx};
endmodule

// File: rtl/pgwr_engine_chk.sv
module pgwr_engine_chk
    import pgwr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int COL_W     = 4,
    parameter int WR_CYCLES = 1000000
) (
    input logic              clk,
    input logic              rst,
    input logic              data_stb,
    input logic              stop_evt,
    input logic              stop_after_ack,
    input logic              ack_valid,
    input logic              ack_ok,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              prot
);
    localparam int unsigned SPAN = busy_span(1 << COL_W, WR_CYCLES);

    int unsigned run_len;

    always_ff @(posedge clk) begin
        if (rst)
            run_len <= 0;
        else if (busy)
            run_len <= run_len + 1;
        else
            run_len <= 0;
    end

    AST_ACK_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> $past(data_stb));                                        // R2

    AST_ROW_FIXED: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |->
            mem_addr[ADDR_W-1:COL_W] == $past(mem_addr[ADDR_W-1:COL_W]));      // R3

    AST_COL_ASCENDING: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |->
            mem_addr[COL_W-1:0] > $past(mem_addr[COL_W-1:0]));                 // R5

    AST_COMMIT_ON_ACK_STOP: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_evt && stop_after_ack));                    // R6

    AST_PROT_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && $past(prot)) |-> !ack_ok);                               // R7

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == SPAN));                                    // R8

    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && $past(busy)) |-> !ack_ok);                               // R9
endmodule

bind pgwr_engine pgwr_engine_chk #(
    .ADDR_W    (ADDR_W),
    .COL_W     (COL_W),
    .WR_CYCLES (WR_CYCLES)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .data_stb       (data_stb),
    .stop_evt       (stop_evt),
    .stop_after_ack (stop_after_ack),
    .ack_valid      (ack_valid),
    .ack_ok         (ack_ok),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .busy           (busy),
    .prot           (prot)
);

// File: tb/pgwr_engine_test.sv
module pgwr_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 24;
    localparam int SPAN = 16 + HOLD;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       xfer_start = 1'b0;
    logic       wp_in = 1'b0;
    logic       addr_load = 1'b0;
    logic [7:0] addr_in = '0;
    logic       data_stb = 1'b0;
    logic [7:0] data_in = '0;
    logic       stop_evt = 1'b0;
    logic       stop_after_ack = 1'b0;
    logic       ack_valid, ack_ok, mem_we, busy;
    logic [7:0] mem_addr, mem_wdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [7:0]  mem [256];
    bit          ack_q [$];
    logic [15:0] wr_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pgwr_engine #(.WR_CYCLES(HOLD)) uut (
        .clk(clk), .rst(rst), .xfer_start(xfer_start), .wp_in(wp_in),
        .addr_load(addr_load), .addr_in(addr_in), .data_stb(data_stb),
        .data_in(data_in), .stop_evt(stop_evt), .stop_after_ack(stop_after_ack),
        .ack_valid(ack_valid), .ack_ok(ack_ok), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy)
    );

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    end

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops scoreboard items as the design produces them
    always @(negedge clk) begin
        if (!rst) begin
            if (ack_valid) begin
                if (ack_q.size() == 0) check(1'b0, "R2 unexpected ack", ack_ok, 0);
                else begin
                    bit e;
                    e = ack_q.pop_front();
                    check(ack_ok == e, "R2/R7/R9 ack decision", ack_ok, e);
                end
            end
            if (mem_we) begin
                if (wr_q.size() == 0) check(1'b0, "R5/R6 unexpected write", {mem_addr, mem_wdata}, 0);
                else begin
                    logic [15:0] e;
                    e = wr_q.pop_front();
                    check({mem_addr, mem_wdata} == e, "R3/R4/R5 write item", {mem_addr, mem_wdata}, e);
                end
            end
        end
    end

    task automatic tick(); @(negedge clk); endtask

    task automatic do_start(input bit wp);
        wp_in = wp; xfer_start = 1'b1; tick(); xfer_start = 1'b0; wp_in = 1'b0; tick();
    endtask

    task automatic do_addr(input logic [7:0] a, input bit wp);
        wp_in = wp; addr_in = a; addr_load = 1'b1; tick(); addr_load = 1'b0; wp_in = 1'b0; tick();
    endtask

    task automatic do_data(input logic [7:0] d, input bit exp_ack);
        ack_q.push_back(exp_ack);
        data_in = d; data_stb = 1'b1; tick(); data_stb = 1'b0; tick();
    endtask

    task automatic do_stop(input bit after_ack);
        stop_evt = 1'b1; stop_after_ack = after_ack; tick();
        stop_evt = 1'b0; stop_after_ack = 1'b0;
    endtask

    task automatic expect_wr(input logic [7:0] a, input logic [7:0] d);
        wr_q.push_back({a, d});
    endtask

    task automatic measure_busy(input string req);
        int n = 0;
        while (busy && n < 1000) begin n++; tick(); end
        check(n == SPAN, req, n, SPAN);
    endtask

    task automatic idle_quiet(input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (busy) seen = 1'b1;
            tick();
        end
        check(!seen, req, seen, 0);
    endtask

    initial begin
        repeat (3) tick();
        // R1 reset state
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(ack_valid == 1'b0, "R1 ack_valid", ack_valid, 0);
        check(mem_we == 1'b0, "R1 mem_we", mem_we, 0);
        rst = 1'b0;
        tick();

        // R2 R5 R8 single byte write
        do_start(1'b0); do_addr(8'h35, 1'b0);
        do_data(8'hA5, 1'b1);
        expect_wr(8'h35, 8'hA5);
        do_stop(1'b1);
        measure_busy("R8 busy span byte write");
        check(mem[8'h35] == 8'hA5, "R5 written byte", mem[8'h35], 8'hA5);
        check(mem[8'h34] == 8'hFF, "R5 neighbour untouched", mem[8'h34], 8'hFF);

        // R3 wrap within row
        do_start(1'b0); do_addr(8'h7E, 1'b0);
        do_data(8'h11, 1'b1); do_data(8'h22, 1'b1); do_data(8'h33, 1'b1);
        expect_wr(8'h70, 8'h33); expect_wr(8'h7E, 8'h11); expect_wr(8'h7F, 8'h22);
        do_stop(1'b1);
        measure_busy("R8 busy span page write");
        check(mem[8'h70] == 8'h33, "R3 wrapped to column 0", mem[8'h70], 8'h33);
        check(mem[8'h80] == 8'hFF, "R3 next row untouched", mem[8'h80], 8'hFF);

        // R4 seventeen bytes overwrite wrapped column
        do_start(1'b0); do_addr(8'h20, 1'b0);
        for (int k = 0; k < 17; k++) do_data(8'h40 + 8'(k), 1'b1);
        expect_wr(8'h20, 8'h50);
        for (int k = 1; k < 16; k++) expect_wr(8'h20 + 8'(k), 8'h40 + 8'(k));
        do_stop(1'b1);
        measure_busy("R8 busy span full row");
        check(mem[8'h20] == 8'h50, "R4 last value wins", mem[8'h20], 8'h50);
        check(mem[8'h2F] == 8'h4F, "R4 last column", mem[8'h2F], 8'h4F);

        // R6 stop not after ack discards
        do_start(1'b0); do_addr(8'h90, 1'b0);
        do_data(8'h5A, 1'b1);
        do_stop(1'b0);
        idle_quiet("R6 misplaced stop no cycle");
        check(mem[8'h90] == 8'hFF, "R6 location unchanged", mem[8'h90], 8'hFF);

        // R10 address only, then committing stop
        do_start(1'b0); do_addr(8'h91, 1'b0);
        do_stop(1'b1);
        idle_quiet("R10 empty buffer no cycle");

        // R7 protect at start
        do_start(1'b1); do_addr(8'hA0, 1'b0);
        do_data(8'h01, 1'b0); do_data(8'h02, 1'b0);
        do_stop(1'b1);
        idle_quiet("R7 protected at start no cycle");
        check(mem[8'hA0] == 8'hFF, "R7 protected location", mem[8'hA0], 8'hFF);

        // R7 protect during address cycle
        do_start(1'b0); do_addr(8'hA4, 1'b1);
        do_data(8'h03, 1'b0);
        do_stop(1'b1);
        idle_quiet("R7 protected at address no cycle");
        check(mem[8'hA4] == 8'hFF, "R7 protected address location", mem[8'hA4], 8'hFF);

        // R7 protect after the window has no effect
        do_start(1'b0); do_addr(8'hB2, 1'b0);
        wp_in = 1'b1;
        do_data(8'hC3, 1'b1);
        wp_in = 1'b0;
        expect_wr(8'hB2, 8'hC3);
        do_stop(1'b1);
        measure_busy("R8 busy span late wp");
        check(mem[8'hB2] == 8'hC3, "R7 late wp ignored", mem[8'hB2], 8'hC3);

        // R9 traffic while busy
        do_start(1'b0); do_addr(8'hC0, 1'b0);
        do_data(8'h77, 1'b1);
        expect_wr(8'hC0, 8'h77);
        do_stop(1'b1);
        check(busy == 1'b1, "R9 busy after commit", busy, 1);
        do_start(1'b0); do_addr(8'hD5, 1'b0);
        do_data(8'h66, 1'b0);
        do_stop(1'b1);
        while (busy) tick();
        idle_quiet("R9 no second cycle");
        check(mem[8'hD5] == 8'hFF, "R9 busy byte not stored", mem[8'hD5], 8'hFF);
        check(mem[8'hC0] == 8'h77, "R9 first commit done", mem[8'hC0], 8'h77);

        // R2 normal service after polling
        do_start(1'b0); do_addr(8'hD6, 1'b0);
        do_data(8'h12, 1'b1);
        expect_wr(8'hD6, 8'h12);
        do_stop(1'b1);
        measure_busy("R8 busy span after poll");

        repeat (4) tick();
        check(ack_q.size() == 0, "R2 pending acks", ack_q.size(), 0);
        check(wr_q.size() == 0, "R5 pending writes", wr_q.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule